// File: doc/BRIEF.md
# Field-Masked Alarm Matcher with Interrupt Control

This block watches a running BCD time-of-day word and compares it with a programmable alarm word. The seconds, minutes and hours fields of the alarm word each carry their own enable bit. A field whose enable is clear takes no part in the compare. The compare runs only on the cycle that carries the one-second tick. When every enabled field matches, a sticky alarm flag is set, so one matching second sets the flag once.

The block also holds three sticky status flags and their interrupt mask: update acknowledge, alarm and second event. Software sets mask bits through a write-only enable command and clears them through a write-only disable command, and reads the resulting mask back. Status flags are cleared through a write-only clear command. A single active-high interrupt line reports any flag that is set while its mask bit is set. All pins are plain control and status signals. The block has no streaming data path, so it has no valid/ready interface and no back-pressure rules.

Top module: `alarm_irq_top`

## Requirements
- R1: After reset, status_o and mask_o are 0 and irq_o is low. The stored alarm word is 0, so every field enable is off.
- R2: Alarm word layout: seconds in bits 6:0 with enable bit 7; minutes in bits 14:8 with enable bit 15; hours in bits 21:16 with AM/PM in bit 22 and enable bit 23 (AM/PM is part of the hour compare). time_i uses the same positions. With all three enables set, a tick whose time equals the alarm sets status_o[1] one clock later.
- R3: A field whose enable is 0 is left out of the compare. With only the seconds enable set, a hit occurs on every tick whose seconds equal the alarm seconds, i.e. once per minute.
- R4: If no field enable is set, no tick ever sets the alarm flag.
- R5: The compare is evaluated only on cycles with sec_tick_i high. A matching time_i without a tick does not set the alarm flag.
- R6: Status bits (bit 0 update acknowledge, bit 1 alarm, bit 2 second event) are sticky. Writing the clear command with a 1 in a bit clears that flag one clock later. Writing 0 has no effect.
- R7: If a clear and a new event for the same flag fall in the same cycle, the flag stays set.
- R8: An enable command with a 1 in a bit sets that mask bit one clock later. Bits written 0 are unchanged. Without a command, the mask holds.
- R9: A disable command with a 1 in a bit clears that mask bit one clock later. If enable and disable name the same bit in one cycle, the disable wins.
- R10: irq_o is high exactly while some status bit and its mask bit are both 1.
- R11: ack_evt_i sets status_o[0], and sec_tick_i sets status_o[2], one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| time_i | input | 23 | Current BCD time word (layout as in R2) |
| sec_tick_i | input | 1 | One-second tick, one clock wide |
| alarm_wr_i | input | 1 | Load alarm word from alarm_wdata_i |
| alarm_wdata_i | input | 32 | Alarm word to load (bits 31:24 ignored) |
| ien_wr_i | input | 1 | Interrupt enable command strobe |
| idis_wr_i | input | 1 | Interrupt disable command strobe |
| clr_wr_i | input | 1 | Status clear command strobe |
| cmd_wdata_i | input | 3 | Bit vector for enable, disable and clear commands |
| ack_evt_i | input | 1 | Raw update-acknowledge event |
| status_o | output | 3 | Sticky status flags |
| mask_o | output | 3 | Interrupt mask readback |
| irq_o | output | 1 | Interrupt, active high |

## Verification
The properties assume sec_tick_i lasts one clock and that the event inputs are clean single-cycle pulses. They do not assume that the command strobes are exclusive. Enable, disable and clear may share a cycle and share cmd_wdata_i, and the mask and clear properties are written with that in mind. The stimulus holds ticks and events to single cycles and drives all inputs on the falling edge. It deliberately places enable with disable, and clear with a fresh event, in the same cycle to reach the R7 and R9 corner cases.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int NSRC   = 3;
  localparam int SRC_ACK = 0;
  localparam int SRC_ALM = 1;
  localparam int SRC_SEC = 2;

  localparam int NFLD   = 3;
  localparam int TIME_W = 23;
  localparam int ALM_W  = 24;

  // Per-field position of value and enable inside the alarm word.
  localparam int FLD_LSB [NFLD] = '{0, 8, 16};
  localparam int FLD_W   [NFLD] = '{7, 7, 7};
  localparam int FLD_EN  [NFLD] = '{7, 15, 23};
endpackage

// File: rtl/alarm_field_match.sv
module alarm_field_match
  import alarm_irq_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TIME_W-1:0]  time_i,
  input  logic               tick_i,
  input  logic               wr_i,
  input  logic [BUS_W-1:0]   wdata_i,
  output logic               hit_o
);
  logic [ALM_W-1:0] alarm_q;
  logic [NFLD-1:0]  fld_en;
  logic [NFLD-1:0]  fld_eq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    alarm_q <= '0;
    else if (wr_i) alarm_q <= wdata_i[ALM_W-1:0];
  end

  for (genvar f = 0; f < NFLD; f++) begin : g_fld
    localparam int LSB = FLD_LSB[f];
    localparam int W   = FLD_W[f];
    localparam int ENB = FLD_EN[f];
    assign fld_en[f] = alarm_q[ENB];
    assign fld_eq[f] = (alarm_q[LSB +: W] == time_i[LSB +: W]);
  end

  // Disabled fields count as matched; at least one field must be enabled.
  assign hit_o = tick_i && (|fld_en) && (&(~fld_en | fld_eq));

  logic unused_bits;
  assign unused_bits = ^{time_i[7], time_i[15], wdata_i[BUS_W-1:ALM_W]};
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         set_wr_i,
  input  logic         clr_mask_wr_i,
  input  logic         clr_flag_wr_i,
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] flag_q, mask_q;
  logic [N-1:0] set_v, dis_v, clr_v;

  assign set_v = set_wr_i      ? bits_i : '0;
  assign dis_v = clr_mask_wr_i ? bits_i : '0;
  assign clr_v = clr_flag_wr_i ? bits_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      flag_q <= (flag_q & ~clr_v) | evt_i;   // fresh event beats clear
      mask_q <= (mask_q | set_v) & ~dis_v;   // disable beats enable
    end
  end

  assign flags_o = flag_q;
  assign mask_o  = mask_q;
  assign irq_o   = |(flag_q & mask_q);
endmodule

// File: rtl/alarm_irq_top.sv
module alarm_irq_top
  import alarm_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_i,
  input  logic              sec_tick_i,
  input  logic              alarm_wr_i,
  input  logic [31:0]       alarm_wdata_i,
  input  logic              ien_wr_i,
  input  logic              idis_wr_i,
  input  logic              clr_wr_i,
  input  logic [NSRC-1:0]   cmd_wdata_i,
  input  logic              ack_evt_i,
  output logic [NSRC-1:0]   status_o,
  output logic [NSRC-1:0]   mask_o,
  output logic              irq_o
);
  logic             alarm_hit;
  logic [NSRC-1:0]  evt_vec;

  alarm_field_match #(.BUS_W(32)) u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .time_i  (time_i),
    .tick_i  (sec_tick_i),
    .wr_i    (alarm_wr_i),
    .wdata_i (alarm_wdata_i),
    .hit_o   (alarm_hit)
  );

  always_comb begin
    evt_vec          = '0;
    evt_vec[SRC_ACK] = ack_evt_i;
    evt_vec[SRC_ALM] = alarm_hit;
    evt_vec[SRC_SEC] = sec_tick_i;
  end

  irq_flag_ctrl #(.N(NSRC)) u_irq (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_i         (evt_vec),
    .set_wr_i      (ien_wr_i),
    .clr_mask_wr_i (idis_wr_i),
    .clr_flag_wr_i (clr_wr_i),
    .bits_i        (cmd_wdata_i),
    .flags_o       (status_o),
    .mask_o        (mask_o),
    .irq_o         (irq_o)
  );
endmodule

// File: rtl/alarm_irq_chk.sv
module alarm_irq_chk
  import alarm_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [TIME_W-1:0] time_i,
  input logic              sec_tick_i,
  input logic              alarm_wr_i,
  input logic [31:0]       alarm_wdata_i,
  input logic              ien_wr_i,
  input logic              idis_wr_i,
  input logic              clr_wr_i,
  input logic [NSRC-1:0]   cmd_wdata_i,
  input logic              ack_evt_i,
  input logic [NSRC-1:0]   status_o,
  input logic [NSRC-1:0]   mask_o,
  input logic              irq_o
);
  // R5: alarm flag can only rise after a tick cycle
  p_alarm_needs_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[SRC_ALM]) |-> $past(sec_tick_i));

  // R6: alarm flag stays set unless cleared
  p_alarm_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[SRC_ALM] && !(clr_wr_i && cmd_wdata_i[SRC_ALM])) |=> status_o[SRC_ALM]);

  // R6: clear without a fresh event empties the acknowledge flag
  p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr_i && cmd_wdata_i[SRC_ACK] && !ack_evt_i) |=> !status_o[SRC_ACK]);

  // R7: a fresh event wins over a clear in the same cycle
  p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt_i |=> status_o[SRC_ACK]);

  // R8: enable sets requested bits when no disable shares the cycle
  p_mask_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_wr_i && !idis_wr_i) |=> ((mask_o & $past(cmd_wdata_i)) == $past(cmd_wdata_i)));

  // R8: mask holds without a command
  p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien_wr_i && !idis_wr_i) |=> $stable(mask_o));

  // R9: disable clears requested bits, even against an enable
  p_mask_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idis_wr_i |=> ((mask_o & $past(cmd_wdata_i)) == '0));

  // R11: second tick sets the second-event flag
  p_sec_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick_i |=> status_o[SRC_SEC]);

  // R10: no interrupt with an empty mask
  p_irq_needs_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mask_o != '0) && (status_o != '0));
endmodule

bind alarm_irq_top alarm_irq_chk u_chk (.*);

// File: tb/alarm_irq_tb.sv
module alarm_irq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [22:0] time_i = '0;
  logic        sec_tick_i = 0;
  logic        alarm_wr_i = 0;
  logic [31:0] alarm_wdata_i = '0;
  logic        ien_wr_i = 0, idis_wr_i = 0, clr_wr_i = 0;
  logic [2:0]  cmd_wdata_i = '0;
  logic        ack_evt_i = 0;
  logic [2:0]  status_o, mask_o;
  logic        irq_o;

  int    n_checks = 0;
  int    n_fail   = 0;
  int    cycles   = 0;
  string tag      = "R1";
  bit    done     = 0;

  // reference state
  logic [2:0]  m_status = '0, m_mask = '0;
  logic [31:0] m_alarm  = '0;

  alarm_irq_top dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit model_hit(input logic [31:0] a, input logic [22:0] t);
    int  enabled = 0;
    bit  ok = 1;
    if (a[7])  begin enabled++; if (a[6:0]   != t[6:0])   ok = 0; end
    if (a[15]) begin enabled++; if (a[14:8]  != t[14:8])  ok = 0; end
    if (a[23]) begin enabled++; if (a[22:16] != t[22:16]) ok = 0; end
    return (enabled > 0) && ok;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_status = '0; m_mask = '0; m_alarm = '0;
    end else begin
      logic [2:0] ev, cl, en, ds;
      ev = {sec_tick_i, sec_tick_i && model_hit(m_alarm, time_i), ack_evt_i};
      cl = clr_wr_i  ? cmd_wdata_i : 3'b000;
      en = ien_wr_i  ? cmd_wdata_i : 3'b000;
      ds = idis_wr_i ? cmd_wdata_i : 3'b000;
      m_status = (m_status & ~cl) | ev;
      m_mask   = (m_mask | en) & ~ds;
      if (alarm_wr_i) m_alarm = alarm_wdata_i;
    end
  end

  task automatic check(input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // compare on every clock, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      check("status", status_o, m_status);
      check("mask",   mask_o,   m_mask);
      check("irq",    irq_o,    |(m_status & m_mask));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input logic [22:0] t);
    @(negedge clk); time_i = t; sec_tick_i = 1;
    @(negedge clk); sec_tick_i = 0;
  endtask

  task automatic load_alarm(input logic [31:0] w);
    @(negedge clk); alarm_wr_i = 1; alarm_wdata_i = w;
    @(negedge clk); alarm_wr_i = 0;
  endtask

  task automatic cmd(input bit en, input bit ds, input bit cl, input logic [2:0] d);
    @(negedge clk); ien_wr_i = en; idis_wr_i = ds; clr_wr_i = cl; cmd_wdata_i = d;
    @(negedge clk); ien_wr_i = 0; idis_wr_i = 0; clr_wr_i = 0; cmd_wdata_i = '0;
  endtask

  function automatic logic [22:0] hms(input logic [6:0] h, input logic [6:0] m, input logic [6:0] s);
    return {h, 1'b0, m, 1'b0, s};
  endfunction

  initial begin
    idle(2);
    @(negedge clk); rst_n = 1;
    tag = "R1"; idle(3);
    check("reset status", status_o, 0);
    check("reset mask",   mask_o,   0);
    check("reset irq",    irq_o,    0);

    tag = "R8"; cmd(1, 0, 0, 3'b010); cmd(1, 0, 0, 3'b000); idle(1);
    check("mask after enable", mask_o, 3'b010);

    tag = "R4"; tick(hms(7'h00, 7'h00, 7'h00)); idle(1);
    check("no enables no alarm", status_o[1], 0);
    cmd(0, 0, 1, 3'b100);

    tag = "R2";
    load_alarm({8'h00, 1'b1, 7'h12, 1'b1, 7'h34, 1'b1, 7'h56});
    tick(hms(7'h12, 7'h34, 7'h55)); idle(1);
    check("one second early", status_o[1], 0);
    tick(hms(7'h12, 7'h34, 7'h56)); idle(1);
    check("exact match", status_o[1], 1);
    check("irq on alarm", irq_o, 1);

    tag = "R6"; cmd(0, 0, 1, 3'b000); idle(1);
    check("clear zero no effect", status_o[1], 1);
    cmd(0, 0, 1, 3'b110); idle(1);
    check("alarm cleared", status_o[1], 0);
    check("irq drops", irq_o, 0);

    tag = "R5";
    @(negedge clk); time_i = hms(7'h12, 7'h34, 7'h56); idle(4);
    check("no tick no alarm", status_o[1], 0);

    tag = "R3";
    load_alarm({8'h00, 1'b0, 7'h05, 1'b0, 7'h09, 1'b1, 7'h30});
    tick(hms(7'h01, 7'h00, 7'h30)); idle(1);
    check("seconds only hit 1", status_o[1], 1);
    cmd(0, 0, 1, 3'b010);
    tick(hms(7'h01, 7'h01, 7'h30)); idle(1);
    check("seconds only hit next minute", status_o[1], 1);
    cmd(0, 0, 1, 3'b010);
    tick(hms(7'h01, 7'h01, 7'h31)); idle(1);
    check("seconds mismatch", status_o[1], 0);
    // hour-only alarm at 11 PM: AM/PM bit joins the compare
    load_alarm({8'h00, 1'b1, 7'h51, 1'b0, 7'h00, 1'b0, 7'h00});
    tick(hms(7'h11, 7'h22, 7'h10)); idle(1);
    check("AM does not match PM", status_o[1], 0);
    tick(hms(7'h51, 7'h22, 7'h10)); idle(1);
    check("PM hour match", status_o[1], 1);

    tag = "R7";
    @(negedge clk); time_i = hms(7'h51, 7'h40, 7'h00); sec_tick_i = 1;
    clr_wr_i = 1; cmd_wdata_i = 3'b110;
    @(negedge clk); sec_tick_i = 0; clr_wr_i = 0; cmd_wdata_i = '0;
    check("alarm kept over clear", status_o[1], 1);
    check("sec kept over clear", status_o[2], 1);
    @(negedge clk); ack_evt_i = 1; clr_wr_i = 1; cmd_wdata_i = 3'b001;
    @(negedge clk); ack_evt_i = 0; clr_wr_i = 0; cmd_wdata_i = '0;
    check("ack kept over clear", status_o[0], 1);

    tag = "R9"; cmd(0, 1, 0, 3'b010); idle(1);
    check("alarm mask cleared", mask_o[1], 0);
    check("irq off with empty mask", irq_o, 0);
    cmd(1, 1, 0, 3'b100); idle(1);
    check("disable beats enable", mask_o[2], 0);

    tag = "R11"; cmd(0, 0, 1, 3'b111); idle(1);
    check("all cleared", status_o, 0);
    @(negedge clk); ack_evt_i = 1;
    @(negedge clk); ack_evt_i = 0;
    check("ack flag", status_o, 3'b001);
    tick(hms(7'h00, 7'h00, 7'h01)); idle(1);
    check("second flag", status_o[2], 1);

    tag = "R10"; cmd(1, 0, 0, 3'b001); idle(1);
    check("irq from ack", irq_o, 1);
    cmd(0, 0, 1, 3'b001); idle(1);
    check("irq off after clear", irq_o, 0);
    cmd(1, 0, 0, 3'b100); idle(1);
    check("irq from second", irq_o, 1);
    idle(3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule